// File: doc/BRIEF.md
# Synchronous burst SRAM cycle controller

This block is a clocked memory, four byte lanes wide (32 bits by default), with a small internal word array and a two-bit burst counter. On every rising clock edge it looks at three chip enables, two address-start strobes, an advance input and the write controls. From these it decides which kind of cycle is running:

- deselect;
- begin burst at an external address;
- continue burst at the next address in the burst order;
- suspend burst at the current address.

Each cycle is either a read or a write.

Two start strobes exist. The host strobe always begins a read and is qualified by the first enable. The controller strobe begins a read or a write, depending on the write controls. Writes are steered to byte lanes by a global write input or by a byte-write enable combined with one enable per lane. A read returns its word one cycle after its address is taken. The word leaves on a data port whose drive flag follows an asynchronous output enable.

The burst order follows the order-select input. With order-select low, the low two address bits count up and wrap. With order-select high, they are the starting bits XOR the beat number.

Top module: `burst_sram_ctrl`

## Requirements
- R1: The block counts as selected only when `en_a_n`=0, `en_b_n`=0 and `en_c`=1. A deselect cycle occurs in two cases: `start_any_n`=0 while not selected, or `start_rd_n`=0 with `en_a_n`=0 while another enable deselects. A deselect cycle ends the burst. After it the data is not driven, and later advance cycles neither read nor write until a new burst begins.
- R2: `start_rd_n`=0 with the block selected begins a read at `addr_in`, whatever the write inputs are. Nothing is written. The word at that address is driven after the next clock edge.
- R3: `start_rd_n` has no effect while `en_a_n`=1. The cycle is then decoded from `start_any_n` and `step_n` alone.
- R4: `start_any_n`=0 with `start_rd_n` inactive and the block selected loads `addr_in`. If the combined write is active, the cycle is a write that stores `data_in` on that same edge. Otherwise the cycle is a read.
- R5: With both strobes high and a burst in progress, the chip enables are ignored. `step_n`=0 moves to the next burst address. `step_n`=1 stays on the current address. Either cycle is a read or a write according to the combined write.
- R6: With `order_sel`=0, the low two address bits of beat k are (start + k) mod 4. The upper bits stay fixed.
- R7: With `order_sel`=1, the low two address bits of beat k are start XOR k.
- R8: The combined write is active when `wr_all_n`=0, or when `wr_byte_n`=0 and at least one `lane_sel_n` bit is 0. With `wr_all_n`=0, all lanes are written. Otherwise each `lane_sel_n[i]`=0 writes bits 8i+7:8i; lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R9: After a host-strobe read, asserting a write on the following wait cycle (both strobes high, `step_n`=1) writes the same address. The read still returns the old word.
- R10: `data_oe` is 1 only when the cycle two edges back was a read and `out_en_n`=0. It follows `out_en_n` without waiting for a clock. `data_out` is 0 whenever `data_oe` is 0.
- R11: After reset, `data_oe` is 0 and no burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en_a_n | input | 1 | Active-low enable; also qualifies the host strobe |
| en_b_n | input | 1 | Active-low enable |
| en_c | input | 1 | Active-high enable |
| start_rd_n | input | 1 | Host start strobe, active low, always a read |
| start_any_n | input | 1 | Controller start strobe, active low |
| step_n | input | 1 | Active-low burst advance; high suspends |
| wr_all_n | input | 1 | Active-low write of all lanes |
| wr_byte_n | input | 1 | Active-low byte-write enable |
| lane_sel_n | input | 4 | Active-low per-lane write enables |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | 6 | External word address |
| data_in | input | 32 | Write data |
| data_out | output | 32 | Read data, 0 when not driven |
| data_oe | output | 1 | High when `data_out` is driven |

## Verification
Writes take effect on the edge that carries the write command. Read data and its drive flag appear after the edge following the cycle that took the address. The bench therefore keeps a two-stage model: the word read and the read flag move into the model's output stage one edge after the model decodes the cycle. The model reads the array before applying a write on the same edge, so a write on a wait cycle that follows a read still returns the old word. Outputs are compared a short delay after each edge. The output-enable checks toggle `out_en_n` between edges and look at `data_oe` with no clock in between.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_DESEL = 3'd1,
    CYC_BEGIN = 3'd2,
    CYC_CONT  = 3'd3,
    CYC_SUSP  = 3'd4
  } cyc_e;

  function automatic logic cyc_moves(cyc_e c);
    return (c == CYC_BEGIN) || (c == CYC_CONT) || (c == CYC_SUSP);
  endfunction

endpackage

// File: rtl/sbc_decode.sv
module sbc_decode #(
  parameter int LANES = 4
) (
  input  logic             en_a_n,
  input  logic             en_b_n,
  input  logic             en_c,
  input  logic             start_rd_n,
  input  logic             start_any_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             burst_on,
  output sbc_pkg::cyc_e    cyc,
  output logic             is_wr,
  output logic [LANES-1:0] lane_we
);
  import sbc_pkg::*;

  logic             selected;
  logic             host_go;
  logic [LANES-1:0] lane_mask;
  logic             wr_req;

  always_comb begin
    selected = !en_a_n && !en_b_n && en_c;
    host_go  = !start_rd_n && !en_a_n;
    if (!wr_all_n)       lane_mask = '1;
    else if (!wr_byte_n) lane_mask = ~lane_sel_n;
    else                 lane_mask = '0;
    wr_req = |lane_mask;
  end

  always_comb begin
    cyc   = CYC_IDLE;
    is_wr = 1'b0;
    if (host_go) begin
      cyc = selected ? CYC_BEGIN : CYC_DESEL;
    end else if (!start_any_n) begin
      cyc   = selected ? CYC_BEGIN : CYC_DESEL;
      is_wr = selected && wr_req;
    end else if (burst_on) begin
      cyc   = step_n ? CYC_SUSP : CYC_CONT;
      is_wr = wr_req;
    end
    lane_we = is_wr ? lane_mask : '0;
  end

endmodule

// File: rtl/sbc_addr.sv
module sbc_addr #(
  parameter int AW = 6,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  sbc_pkg::cyc_e cyc,
  input  logic          order_sel,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] cur_addr
);
  import sbc_pkg::*;

  logic [BB-1:0] base_lo;
  logic [BB-1:0] beat;
  logic [BB-1:0] beat_nx;
  logic [BB-1:0] lo_nx;

  always_comb begin
    beat_nx = beat + 1'b1;
    lo_nx   = order_sel ? (base_lo ^ beat_nx) : (base_lo + beat_nx);
    case (cyc)
      CYC_BEGIN: eff_addr = ext_addr;
      CYC_CONT:  eff_addr = {cur_addr[AW-1:BB], lo_nx};
      default:   eff_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo  <= '0;
      beat     <= '0;
      cur_addr <= '0;
    end else begin
      if (cyc == CYC_BEGIN) begin
        base_lo <= ext_addr[BB-1:0];
        beat    <= '0;
      end else if (cyc == CYC_CONT) begin
        beat <= beat_nx;
      end
      if (cyc_moves(cyc)) cur_addr <= eff_addr;
    end
  end

  a_r5_suspend_holds: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_SUSP) |=> (cur_addr == $past(cur_addr)));
  a_r5_continue_steps: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_CONT) |=> (beat == BB'($past(beat) + 1'b1)));
  a_r2_begin_loads: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_BEGIN) |=> (cur_addr == $past(ext_addr) && beat == '0));
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_CONT) |=> (cur_addr[AW-1:BB] == $past(cur_addr[AW-1:BB])));

endmodule

// File: rtl/sbc_array.sv
module sbc_array #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic [LANES-1:0]    lane_we,
  input  logic [AW-1:0]       waddr,
  input  logic [LANES*LW-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic [LANES*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[g]) store[waddr] <= wdata[g*LW +: LW];
      rdata[g*LW +: LW] <= store[raddr];
    end
  end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 8,
  parameter int BB    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_a_n,
  input  logic                en_b_n,
  input  logic                en_c,
  input  logic                start_rd_n,
  input  logic                start_any_n,
  input  logic                step_n,
  input  logic                wr_all_n,
  input  logic                wr_byte_n,
  input  logic [LANES-1:0]    lane_sel_n,
  input  logic                out_en_n,
  input  logic                order_sel,
  input  logic [AW-1:0]       addr_in,
  input  logic [LANES*LW-1:0] data_in,
  output logic [LANES*LW-1:0] data_out,
  output logic                data_oe
);
  import sbc_pkg::*;

  localparam int DW = LANES * LW;

  cyc_e             cyc;
  logic             is_wr;
  logic [LANES-1:0] lane_we;
  logic [AW-1:0]    eff_addr;
  logic [AW-1:0]    cur_addr;
  logic [DW-1:0]    rd_word;
  logic             burst_on;
  logic             rd_pend;
  logic             rd_valid;

  sbc_decode #(.LANES(LANES)) u_dec (
    .en_a_n(en_a_n), .en_b_n(en_b_n), .en_c(en_c),
    .start_rd_n(start_rd_n), .start_any_n(start_any_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
    .burst_on(burst_on), .cyc(cyc), .is_wr(is_wr), .lane_we(lane_we)
  );

  sbc_addr #(.AW(AW), .BB(BB)) u_addr (
    .clk(clk), .rst(rst), .cyc(cyc), .order_sel(order_sel),
    .ext_addr(addr_in), .eff_addr(eff_addr), .cur_addr(cur_addr)
  );

  sbc_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_mem (
    .clk(clk), .lane_we(lane_we), .waddr(eff_addr), .wdata(data_in),
    .raddr(cur_addr), .rdata(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_on <= 1'b0;
      rd_pend  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_pend;
      rd_pend  <= cyc_moves(cyc) && !is_wr;
      if (cyc == CYC_BEGIN)      burst_on <= 1'b1;
      else if (cyc == CYC_DESEL) burst_on <= 1'b0;
    end
  end

  always_comb begin
    data_oe  = rd_valid && !out_en_n;
    data_out = data_oe ? rd_word : '0;
  end

  a_r10_drive_needs_enable: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> !out_en_n);
  a_r1_desel_ends_burst: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_DESEL) |=> (!burst_on && !rd_pend));
  a_r4_write_not_read: assert property (@(posedge clk) disable iff (rst)
    (is_wr && cyc_moves(cyc)) |=> !rd_pend);
  a_r2_host_reads: assert property (@(posedge clk) disable iff (rst)
    (!start_rd_n && !en_a_n && !en_b_n && en_c) |-> (lane_we == '0));
  a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!data_oe && !rd_pend));

endmodule

// File: tb/burst_sram_ctrl_test.sv
module burst_sram_ctrl_test;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_a_n = 1'b0, en_b_n = 1'b0, en_c = 1'b1;
  logic start_rd_n = 1'b1, start_any_n = 1'b1, step_n = 1'b1;
  logic wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [3:0] lane_sel_n = 4'hF;
  logic out_en_n = 1'b0, order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [31:0] data_in = '0;
  logic [31:0] data_out;
  logic data_oe;

  int n_chk = 0, n_bad = 0;

  // model state
  logic [31:0]   mmem [DEPTH];
  logic          m_active, m_pend, m_valid;
  logic [AW-1:0] m_cur;
  logic [1:0]    m_lo, m_cnt;
  logic [31:0]   m_data;

  always #10 clk = ~clk;

  burst_sram_ctrl uut (
    .clk(clk), .rst(rst), .en_a_n(en_a_n), .en_b_n(en_b_n), .en_c(en_c),
    .start_rd_n(start_rd_n), .start_any_n(start_any_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .order_sel(order_sel), .addr_in(addr_in),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
  );

  function automatic logic [31:0] fillval(input logic [AW-1:0] a);
    return 32'hC0DE0000 | ({26'd0, a} * 32'h00000101);
  endfunction

  function automatic logic [1:0] beat_lo(input logic [1:0] lo, input logic [1:0] k, input logic il);
    return il ? (lo ^ k) : (lo + k);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic sel, hostv, wr;
    logic [3:0] mask;
    logic [AW-1:0] eff;
    int kind;
    logic nv;
    logic [31:0] nd;
    nv = m_pend;
    nd = mmem[m_cur];
    sel   = !en_a_n && !en_b_n && en_c;
    hostv = !start_rd_n && !en_a_n;
    mask  = !wr_all_n ? 4'hF : (!wr_byte_n ? ~lane_sel_n : 4'h0);
    wr    = |mask;
    eff   = m_cur;
    if (hostv) begin kind = sel ? 2 : 1; wr = 1'b0; end
    else if (!start_any_n) kind = sel ? 2 : 1;
    else if (m_active) kind = step_n ? 4 : 3;
    else kind = 0;
    if (kind == 2) begin
      eff = addr_in; m_lo = addr_in[1:0]; m_cnt = 2'd0; m_active = 1'b1;
    end else if (kind == 3) begin
      m_cnt = m_cnt + 2'd1;
      eff = {m_cur[AW-1:2], beat_lo(m_lo, m_cnt, order_sel)};
    end else if (kind == 1) begin
      m_active = 1'b0;
    end
    if (kind >= 2) begin
      m_cur  = eff;
      m_pend = !wr;
      if (wr) for (int i = 0; i < 4; i++)
        if (mask[i]) mmem[eff][i*8 +: 8] = data_in[i*8 +: 8];
    end else begin
      m_pend = 1'b0;
    end
    m_valid = nv;
    m_data  = nd;
  endtask

  task automatic step(input string tag);
    logic eoe;
    model_edge();
    @(posedge clk);
    #2;
    eoe = m_valid && !out_en_n;
    check({tag, " drive"}, {31'd0, data_oe}, {31'd0, eoe});
    check({tag, " data"}, data_out, eoe ? m_data : 32'd0);
  endtask

  task automatic quiet();
    start_rd_n = 1; start_any_n = 1; step_n = 1; wr_all_n = 1; wr_byte_n = 1;
    lane_sel_n = 4'hF; en_a_n = 0; en_b_n = 0; en_c = 1; out_en_n = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < DEPTH; i++) mmem[i] = 32'd0;
    m_active = 0; m_pend = 0; m_valid = 0; m_cur = '0; m_lo = 0; m_cnt = 0; m_data = 0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R11: reset state, advance with write asserted does nothing
    check("R11 idle drive", {31'd0, data_oe}, 32'd0);
    step_n = 0; wr_all_n = 0;
    step("R11"); step("R11");
    check("R11 no burst", {31'd0, data_oe}, 32'd0);
    quiet();
    // fill through controller-strobe writes (R4)
    for (int a = 0; a < DEPTH; a++) begin
      start_any_n = 0; wr_all_n = 0; addr_in = AW'(a); data_in = fillval(AW'(a));
      step("R4 fill");
    end
    quiet();
    // R2: host read with write inputs active reads, writes nothing
    start_rd_n = 0; wr_all_n = 0; addr_in = 6'd5; data_in = 32'hDEADBEEF;
    step("R2");
    quiet(); step("R2");
    check("R2 host read word", data_out, fillval(6'd5));
    // R9: write on wait cycle after host read
    start_rd_n = 0; addr_in = 6'd9; step("R9");
    quiet(); wr_all_n = 0; data_in = 32'h9A9A9A9A; step("R9");
    check("R9 old word returned", data_out, fillval(6'd9));
    quiet(); start_any_n = 0; addr_in = 6'd9; step("R9");
    quiet(); step("R9");
    check("R9 written word", data_out, 32'h9A9A9A9A);
    // R6: linear burst from 13
    order_sel = 0; start_any_n = 0; addr_in = 6'd13; step("R6");
    quiet(); step_n = 0; step("R6"); check("R6 beat0", data_out, fillval(6'd13));
    step("R6"); check("R6 beat1", data_out, fillval(6'd14));
    step("R6"); check("R6 beat2", data_out, fillval(6'd15));
    step_n = 1; step("R5"); check("R6 beat3", data_out, fillval(6'd12));
    step("R5"); check("R5 suspend holds", data_out, fillval(6'd12));
    // R7: interleaved burst from 13
    order_sel = 1; start_any_n = 0; addr_in = 6'd13; step("R7");
    quiet(); step_n = 0; step("R7"); check("R7 beat0", data_out, fillval(6'd13));
    step("R7"); check("R7 beat1", data_out, fillval(6'd12));
    step("R7"); check("R7 beat2", data_out, fillval(6'd15));
    step_n = 1; step("R7"); check("R7 beat3", data_out, fillval(6'd14));
    order_sel = 0;
    // R8: lanes 0 and 2 via byte-write enable
    quiet(); start_any_n = 0; wr_byte_n = 0; lane_sel_n = 4'b1010;
    addr_in = 6'd20; data_in = 32'h11223344; step("R8");
    quiet(); start_any_n = 0; addr_in = 6'd20; step("R8");
    quiet(); step("R8");
    check("R8 lane mask", data_out,
          {fillval(6'd20)[31:24], 8'h22, fillval(6'd20)[15:8], 8'h44});
    // R8/R4: lanes low but byte-write enable high -> read
    quiet(); start_any_n = 0; lane_sel_n = 4'h0; addr_in = 6'd21; data_in = 32'hFFFFFFFF; step("R4");
    quiet(); step("R4");
    check("R4 no combined write reads", data_out, fillval(6'd21));
    // R3: host strobe ignored while en_a_n high; burst suspends at 21
    quiet(); en_a_n = 1; start_rd_n = 0; addr_in = 6'd40; step("R3");
    quiet(); step("R3");
    check("R3 host ignored", data_out, fillval(6'd21));
    // R5: enables ignored during continue
    quiet(); en_c = 0; step_n = 0; step("R5");
    quiet(); step("R5"); check("R5 enables ignored", data_out, fillval(6'd22));
    // R1: controller strobe while deselected
    quiet(); en_b_n = 1; start_any_n = 0; step("R1");
    quiet(); step_n = 0; step("R1"); step("R1");
    check("R1 deselected quiet", {31'd0, data_oe}, 32'd0);
    // R1: host strobe with en_a_n low and en_c low deselects
    quiet(); start_any_n = 0; addr_in = 6'd3; step("R1");
    quiet(); en_c = 0; start_rd_n = 0; step("R1");
    quiet(); step_n = 0; step("R1"); step("R1");
    check("R1 host deselect", {31'd0, data_oe}, 32'd0);
    // R10: asynchronous output enable
    quiet(); start_any_n = 0; addr_in = 6'd7; step("R10");
    quiet(); step("R10");
    #3 out_en_n = 1; #1;
    check("R10 async off", {31'd0, data_oe}, 32'd0);
    check("R10 data zero", data_out, 32'd0);
    #1 out_en_n = 0; #1;
    check("R10 async on", data_out, fillval(6'd7));
    // random phase
    for (int c = 0; c < 3000; c++) begin
      quiet();
      if (c % 200 == 0) order_sel = $urandom_range(0, 1) == 1;
      start_rd_n  = $urandom_range(0, 9) != 0;
      start_any_n = $urandom_range(0, 6) != 0;
      en_a_n = $urandom_range(0, 11) == 0;
      en_b_n = $urandom_range(0, 11) == 0;
      en_c   = $urandom_range(0, 11) != 0;
      step_n = $urandom_range(0, 9) >= 6;
      wr_all_n  = $urandom_range(0, 4) != 0;
      wr_byte_n = $urandom_range(0, 4) >= 2;
      lane_sel_n = 4'($urandom);
      out_en_n = $urandom_range(0, 6) == 0;
      addr_in = AW'($urandom);
      data_in = $urandom;
      step("R5 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule